// File: doc/BRIEF.md
# Chained Serial Result Framer

This block holds a 16-bit conversion result and, on request, shifts it out one bit per clock, most significant bit first. A sync pulse marks the start of each data frame. A frame is the whole word in word mode, or one of two 8-clock halves in byte mode. Several instances can share one serial line. The read request and bus-busy pins form a token chain: each device's bus-busy output drives the read request of the next device along.

In daisy-chain mode the device nearest the host sends its own word first. It then forwards the serial data and sync arriving from upstream, so the upstream device's word follows with no idle clock between the two. In cascade mode nothing is forwarded. A latency select picks the newest captured result or the one captured before it. The chip select gates the data and sync drivers through an output-enable signal, and it aborts a readout that is under way.

Top module: `result_framer`

## Requirements
- R1: A readout starts at the first rising clock edge where `rd_req` is sampled low after being sampled high on the previous edge. Starting requires `cs_n` low and no readout under way. Bit 15 is on `sdo` right after that edge, and each later edge moves one bit lower, down to bit 0.
- R2: `sync_o` is high for exactly one clock together with bit 15. When `byte_mode` is 1 at the start edge, `sync_o` is also high for one clock together with bit 7. This makes two 8-clock frames, upper byte first. When `byte_mode` is 0 there is one 16-clock frame.
- R3: `out_en` is 1 exactly while `cs_n` is 0. A clock edge that samples `cs_n` high ends any readout and any forwarding, and drives `bus_busy` low.
- R4: `bus_busy` rises with the first bit and stays high for 15 clocks. It is low during the clock in which bit 0 is on `sdo`.
- R5: With `chain_sel` = 0 (daisy chain), from the clock after bit 0 `sdo` equals `sdi` and `sync_o` equals `sync_i`, with no register delay. This lasts until `cs_n` is sampled high or a new readout starts.
- R6: With `chain_sel` = 1 (cascade), `sdo` and `sync_o` are 0 after bit 0.
- R7: Each `res_valid` edge stores `res_data` as the newest result and moves the old newest result to the previous slot. `lat_sel` = 0 sends the newest result, and `lat_sel` = 1 sends the previous one.
- R8: A read request that falls while a readout is under way is ignored. The word and its timing are unchanged.
- R9: After reset, and whenever neither a readout nor forwarding is active, `sdo`, `sync_o` and `bus_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock; bits launch on its rising edge |
| rst | input | 1 | synchronous active-high reset |
| cs_n | input | 1 | active-low select; high disables outputs and aborts |
| rd_req | input | 1 | read request / token input from the host or the previous device |
| byte_mode | input | 1 | 1 = two 8-clock frames, 0 = one 16-clock frame |
| chain_sel | input | 1 | 0 = daisy chain (forward upstream), 1 = cascade |
| lat_sel | input | 1 | 0 = newest result, 1 = previous result |
| res_data | input | 16 | parallel conversion result |
| res_valid | input | 1 | strobe that stores `res_data` |
| sdi | input | 1 | serial data from the upstream device |
| sync_i | input | 1 | sync from the upstream device |
| sdo | output | 1 | serial data out, MSB first |
| sync_o | output | 1 | frame sync out |
| out_en | output | 1 | drive enable for `sdo` and `sync_o` |
| bus_busy | output | 1 | token output to the next device's `rd_req` |

## Verification
Two instances are chained, and the bench compares the combined serial stream on every clock against a model. The runs cover word mode with the newest result, byte mode with the previous result, and cascade mode with an extra read pulse mid-word. Together they separate bit order, the placement of the second sync pulse, and which result slot is read. Runs of all ones, all zeros and alternating corner words expose stuck or shifted bits. Forwarding is seen in the upstream word arriving immediately after the local one. A chip-select abort shows the enable and token behaviour.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic {CHAIN_DAISY = 1'b0, CHAIN_CASCADE = 1'b1} chain_e;
endpackage

// File: rtl/rf_result_store.sv
module rf_result_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic [W-1:0] din,
  input  logic         use_prev,
  output logic [W-1:0] word
);
  logic [W-1:0] cur_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else if (valid) begin
      cur_q  <= din;
      prev_q <= cur_q;
    end
  end

  assign word = use_prev ? prev_q : cur_q;
endmodule

// File: rtl/rf_shifter.sv
module rf_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         start,
  input  logic         byte_mode,
  input  logic [W-1:0] word,
  output logic         sdo_r,
  output logic         sync_r,
  output logic         busy,
  output logic         active,
  output logic         finishing
);
  localparam int CNT_W = $clog2(W);
  localparam int HALF  = W / 2;
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(W - 1);
  localparam logic [CNT_W-1:0] MID_PREV = CNT_W'(HALF - 1);

  logic [W-1:0]     sh;
  logic [CNT_W-1:0] cnt;
  logic             bm_q;

  assign finishing = active && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      sh     <= '0;
      cnt    <= '0;
      bm_q   <= 1'b0;
      active <= 1'b0;
      busy   <= 1'b0;
      sdo_r  <= 1'b0;
      sync_r <= 1'b0;
    end else if (start) begin
      sh     <= word;
      cnt    <= '0;
      bm_q   <= byte_mode;
      active <= 1'b1;
      busy   <= 1'b1;
      sdo_r  <= word[W-1];
      sync_r <= 1'b1;
    end else if (active) begin
      if (cnt == LAST) begin
        active <= 1'b0;
        busy   <= 1'b0;
        sdo_r  <= 1'b0;
        sync_r <= 1'b0;
      end else begin
        cnt    <= cnt + 1'b1;
        sh     <= sh << 1;
        sdo_r  <= sh[W-2];
        sync_r <= bm_q && (cnt == MID_PREV);
        busy   <= (cnt != LAST - 1'b1);
      end
    end
  end
endmodule

// File: rtl/result_framer.sv
module result_framer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         rd_req,
  input  logic         byte_mode,
  input  logic         chain_sel,
  input  logic         lat_sel,
  input  logic [W-1:0] res_data,
  input  logic         res_valid,
  input  logic         sdi,
  input  logic         sync_i,
  output logic         sdo,
  output logic         sync_o,
  output logic         out_en,
  output logic         bus_busy
);
  import rf_pkg::*;

  logic         rd_q, pass_q, start;
  logic [W-1:0] word;
  logic         sdo_r, sync_r, active, finishing;
  chain_e       mode;

  assign mode  = chain_e'(chain_sel);
  assign start = rd_q && !rd_req && !cs_n && !active;

  rf_result_store #(.W(W)) u_store (
    .clk(clk), .rst(rst), .valid(res_valid), .din(res_data),
    .use_prev(lat_sel), .word(word)
  );

  rf_shifter #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .cs_n(cs_n), .start(start), .byte_mode(byte_mode),
    .word(word), .sdo_r(sdo_r), .sync_r(sync_r), .busy(bus_busy),
    .active(active), .finishing(finishing)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= rd_req;
  end

  always_ff @(posedge clk) begin
    if (rst || cs_n || start) pass_q <= 1'b0;
    else if (finishing)       pass_q <= (mode == CHAIN_DAISY);
  end

  assign sdo    = pass_q ? sdi    : sdo_r;
  assign sync_o = pass_q ? sync_i : sync_r;
  assign out_en = !cs_n;
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int W = 16
) (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic bus_busy,
  input logic sync_o,
  input logic out_en
);
  logic [$clog2(W)+1:0] run;

  always_ff @(posedge clk) begin
    if (rst)           run <= '0;
    else if (bus_busy) run <= run + 1'b1;
    else               run <= '0;
  end

  // R2: a frame opens with sync on the first bit
  p_sync_first_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_busy) |-> sync_o && out_en);

  // R2: sync is a single-clock pulse
  p_sync_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_busy) |=> !sync_o);

  // R3: deselect drops the token
  p_cs_abort_r3: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !bus_busy);

  // R4: token held for W-1 clocks when not aborted
  p_busy_len_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_busy) && !$past(cs_n)) |-> (run == ($clog2(W)+2)'(W - 1)));
endmodule

bind result_framer rf_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .bus_busy(bus_busy),
  .sync_o(sync_o), .out_en(out_en)
);

// File: tb/sim_result_framer.sv
module sim_result_framer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b0, rd_req = 1'b0, byte_mode = 1'b0, csel0 = 1'b0, lat0 = 1'b0;
  logic [15:0] res0 = '0, res1 = '0;
  logic valid = 1'b0;
  logic sdo0, sync0, oe0, busy0, sdo1, sync1, oe1, busy1;
  int total = 0, bad = 0;
  bit finished = 0;
  logic [15:0] mcur0 = '0, mprev0 = '0, mcur1 = '0, mprev1 = '0;

  always #10 clk = ~clk;

  result_framer u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_req(rd_req), .byte_mode(byte_mode),
    .chain_sel(csel0), .lat_sel(lat0), .res_data(res0), .res_valid(valid),
    .sdi(sdo1), .sync_i(sync1), .sdo(sdo0), .sync_o(sync0), .out_en(oe0),
    .bus_busy(busy0)
  );

  result_framer u1 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_req(busy0), .byte_mode(byte_mode),
    .chain_sel(1'b0), .lat_sel(1'b0), .res_data(res1), .res_valid(valid),
    .sdi(1'b0), .sync_i(1'b0), .sdo(sdo1), .sync_o(sync1), .out_en(oe1),
    .bus_busy(busy1)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    res0 = a; res1 = b; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    mprev0 = mcur0; mcur0 = a;
    mprev1 = mcur1; mcur1 = b;
  endtask

  // chain readout; model covers R1 R2 R4 R5 R6 R7 R8 R9
  task automatic readout(input logic bm, input logic lat, input logic csel, input bit poke);
    logic [15:0] w0, w1;
    @(negedge clk);
    byte_mode = bm; lat0 = lat; csel0 = csel; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    w0 = lat ? mprev0 : mcur0;
    w1 = mcur1;
    for (int i = 0; i < 36; i++) begin
      logic eb, es;
      int k;
      @(negedge clk);
      k = i % 16;
      if (i < 16) begin
        eb = w0[15-k]; es = (k == 0) || (bm && k == 8);
      end else if (i < 32 && !csel) begin
        eb = w1[15-k]; es = (k == 0) || (bm && k == 8);
      end else begin
        eb = 1'b0; es = 1'b0;
      end
      check(sdo0, eb, i < 16 ? "R1/R7 own bit" : (csel ? "R6 cascade idle" : "R5 forwarded bit"));
      check(sync0, es, i < 16 ? "R2 sync" : (csel ? "R6 sync idle" : "R5 R2 forwarded sync"));
      check(busy0, (i < 15), "R4 busy0");
      check(busy1, (i >= 16 && i < 31), "R4 busy1 handoff");
      if (poke && i == 4) rd_req = 1'b1;   // R8 pulse during readout
      if (poke && i == 5) rd_req = 1'b0;
    end
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(sdo0, 1'b0, "R9 reset sdo");
    check(sync0, 1'b0, "R9 reset sync");
    check(busy0, 1'b0, "R9 reset busy");
    check(oe0, 1'b1, "R3 enable with cs low");

    load(16'hA1B2, 16'h5C3E);
    load(16'h8001, 16'h7FFE);
    readout(1'b0, 1'b0, 1'b0, 0);   // word mode, newest, daisy
    readout(1'b1, 1'b1, 1'b0, 0);   // byte mode, previous, daisy
    readout(1'b0, 1'b0, 1'b1, 1);   // cascade, extra pulse ignored
    load(16'hFFFF, 16'h0000);
    load(16'h0000, 16'hAAAA);
    readout(1'b1, 1'b1, 1'b0, 0);   // all ones then alternating
    readout(1'b0, 1'b0, 1'b0, 0);   // all zeros then alternating

    // R3: deselect mid readout
    @(negedge clk);
    byte_mode = 1'b0; lat0 = 1'b0; csel0 = 1'b0; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    repeat (6) @(negedge clk);
    check(busy0, 1'b1, "R3 busy before deselect");
    cs_n = 1'b1;
    #1;
    check(oe0, 1'b0, "R3 out_en off");
    check(oe1, 1'b0, "R3 out_en off upstream");
    @(negedge clk);
    check(busy0, 1'b0, "R3 abort drops busy");
    check(busy1, 1'b0, "R3 upstream not started");
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    check(oe0, 1'b1, "R3 out_en back");
    check(sdo0, 1'b0, "R9 idle sdo after abort");
    check(busy0, 1'b0, "R9 idle busy after abort");
    check(busy1, 1'b0, "R9 idle busy1 after abort");
    finish_run();
  end
endmodule